// File: doc/BRIEF.md
# Eight-Point Forward DCT Pipeline

This block takes one vector of eight signed 16-bit samples per cycle and returns the eight coefficients of its one-dimensional forward discrete cosine transform. It does not multiply by a full cosine matrix. The transform is factored into butterflies. The first add/subtract layer halves every pair sum and pair difference. The even half is then resolved with one more butterfly, a scaling by cos(pi/4) and a single plane rotation. The odd half uses a cos(pi/4) rotation of its two middle terms, a second butterfly against the outer terms, and two final plane rotations. Every constant is the cosine or sine value times 32767, rounded, then halved. The one exception is the full-scale cos(pi/4) used inside the odd half.

The block is meant to be used as the row or column engine of a 2-D transform. The surrounding logic prescales the samples, sequences rows and columns, and quantizes the results. Each product sum is kept at full width. It is then shifted right by 15 with round-half-up and clamped to the signed 16-bit range. The datapath produces the coefficients in the order 0, 4, 2, 6, 1, 5, 3, 7, and the block sorts them into natural index order before driving them out.

Top module: `dct8_fdct`

## Requirements
- R1: A vector accepted in cycle n (in_valid and in_ready both high at a rising edge) appears on the outputs after the fourth following rising edge: out_valid is high for exactly one cycle per accepted vector, and is low when no vector was accepted.
- R2: Outside reset, in_ready is high in every cycle. Vectors offered on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.
- R3: Sample n is taken from in_samples[16n+15:16n]. Coefficient k is driven on out_coef[16k+15:16k], as two's complement values.
- R4: Coefficient 0 equals (1/(4*sqrt 2)) times the sum of the eight samples, within 2 LSB.
- R5: Coefficients 2, 4 and 6 equal one quarter of sum over n of x(n)*cos((2n+1)*k*pi/16), within 2 LSB.
- R6: Coefficients 1, 3, 5 and 7 follow the same formula as R5, within 2 LSB.
- R7: A mirror-symmetric input (x(n) = x(7-n)) gives exactly zero on every odd coefficient.
- R8: A mirror-antisymmetric input (x(n) = -x(7-n)) gives exactly zero on every even coefficient, coefficient 0 included.
- R9: A coefficient whose exact value is above 32767 or below -32768 is driven as 32767 or -32768 respectively. Intermediate sums are carried without clipping.
- R10: While rst_n is low, out_valid, in_ready and out_coef are all zero. A reset discards vectors still in flight. Whenever out_valid is low, out_coef keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample vector on in_samples is offered |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_samples | input | 128 | Eight signed samples, sample n at bits 16n+15:16n |
| out_valid | output | 1 | out_coef carries a new result this cycle |
| out_coef | output | 128 | Eight signed coefficients, coefficient k at bits 16k+15:16k |

## Verification
The stimulus includes mirror-symmetric and mirror-antisymmetric vectors. For these, the bench requires exact zeros on the opposite half of the coefficients. A sign slip in any butterfly or rotation shows up there as a non-zero value, even when the error would stay inside the tolerance. A single impulse placed off-centre exposes swapped lanes or a wrong output order, because each coefficient then has a distinct expected value. Full-scale positive, negative and alternating vectors push coefficients 0 and 7 past the 16-bit range. An intermediate that clips or wraps, or a missing final clamp, then gives a wrong magnitude or a flipped sign. Back-to-back vectors, idle gaps and a reset while a vector is in flight show a valid pulse that is late, duplicated or left over, or outputs that drift while out_valid is low.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int DATA_W = 16;
    localparam int FRAC_W = 15;
    localparam int NPT    = 8;
    localparam int VEC_W  = NPT * DATA_W;
    localparam int EVEN_W = DATA_W + 1;
    localparam int ODD_W  = DATA_W + 2;
    localparam int ACC_W  = 2 * DATA_W + 8;

    typedef logic signed [DATA_W-1:0] smp_t;
    typedef logic signed [EVEN_W-1:0] ev_t;
    typedef logic signed [ODD_W-1:0]  odd_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // Q15 constants: half-scale cos/sin values, plus full-scale cos(pi/4)
    localparam acc_t K_C4F = 40'sd23170;
    localparam acc_t K_C4H = 40'sd11585;
    localparam acc_t K_C6  = 40'sd6270;
    localparam acc_t K_S6  = 40'sd15137;
    localparam acc_t K_C7  = 40'sd3196;
    localparam acc_t K_S7  = 40'sd16069;
    localparam acc_t K_C3  = 40'sd13623;
    localparam acc_t K_S3  = 40'sd9102;

    localparam acc_t SMP_MAX = (acc_t'(1) <<< (DATA_W - 1)) - acc_t'(1);
    localparam acc_t SMP_MIN = -(acc_t'(1) <<< (DATA_W - 1));
    localparam acc_t RND_HALF = acc_t'(1) <<< (FRAC_W - 1);

    // first-layer butterfly results, split by the half that consumes them
    typedef struct packed {
        logic vld;
        smp_t s0;
        smp_t s1;
        smp_t s2;
        smp_t s3;
    } pair_sum_t;

    typedef struct packed {
        logic vld;
        smp_t d0;
        smp_t d1;
        smp_t d2;
        smp_t d3;
    } pair_dif_t;

    typedef struct packed {
        logic vld;
        ev_t  e0;
        ev_t  e1;
        ev_t  e2;
        ev_t  e3;
    } even_mid_t;

    typedef struct packed {
        logic vld;
        smp_t y0;
        smp_t y2;
        smp_t y4;
        smp_t y6;
    } even_out_t;

    typedef struct packed {
        logic vld;
        odd_t rp;
        odd_t rm;
        smp_t o0;
        smp_t o3;
    } odd_rot_t;

    typedef struct packed {
        logic vld;
        odd_t ta;
        odd_t tb;
        odd_t tc;
        odd_t td;
    } odd_mid_t;

    typedef struct packed {
        logic vld;
        smp_t y1;
        smp_t y3;
        smp_t y5;
        smp_t y7;
    } odd_out_t;

    function automatic smp_t half_add(input smp_t a, input smp_t b);
        logic signed [DATA_W:0] t;
        t = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        return t[DATA_W:1];
    endfunction

    function automatic smp_t half_sub(input smp_t a, input smp_t b);
        logic signed [DATA_W:0] t;
        t = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        return t[DATA_W:1];
    endfunction

    function automatic acc_t q15_round(input acc_t v);
        return (v + RND_HALF) >>> FRAC_W;
    endfunction

    function automatic smp_t clamp_smp(input acc_t v);
        if (v > SMP_MAX) begin
            return SMP_MAX[DATA_W-1:0];
        end else if (v < SMP_MIN) begin
            return SMP_MIN[DATA_W-1:0];
        end
        return v[DATA_W-1:0];
    endfunction

    // p*kp + q*kq, rounded back to integer scale and clamped
    function automatic smp_t rot_pair(input acc_t p, input acc_t kp,
                                      input acc_t q, input acc_t kq);
        return clamp_smp(q15_round(p * kp + q * kq));
    endfunction

    // full-scale cos(pi/4) scaling kept unclipped
    function automatic odd_t scale_c4(input acc_t v);
        acc_t t;
        t = q15_round(v * K_C4F);
        return t[ODD_W-1:0];
    endfunction

endpackage

// File: rtl/dct8_bfly.sv
module dct8_bfly
    import dct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [VEC_W-1:0] smp_i,
    output pair_sum_t        sum_o,
    output pair_dif_t        dif_o
);

    typedef struct packed {
        pair_sum_t sm;
        pair_dif_t df;
    } bfly_regs_t;

    bfly_regs_t r_d, r_q;
    smp_t       x [NPT];

    always_comb begin
        for (int n = 0; n < NPT; n++) begin
            x[n] = smp_i[n*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        r_d        = r_q;
        r_d.sm.vld = take_i;
        r_d.df.vld = take_i;
        if (take_i) begin
            r_d.sm.s0 = half_add(x[0], x[7]);
            r_d.sm.s1 = half_add(x[1], x[6]);
            r_d.sm.s2 = half_add(x[2], x[5]);
            r_d.sm.s3 = half_add(x[3], x[4]);
            r_d.df.d0 = half_sub(x[0], x[7]);
            r_d.df.d1 = half_sub(x[1], x[6]);
            r_d.df.d2 = half_sub(x[2], x[5]);
            r_d.df.d3 = half_sub(x[3], x[4]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sum_o = r_q.sm;
    assign dif_o = r_q.df;

endmodule

// File: rtl/dct8_even.sv
module dct8_even
    import dct8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pair_sum_t sum_i,
    output even_out_t ev_o
);

    typedef struct packed {
        even_mid_t mid;
        even_out_t rot;
        even_out_t aln;
    } even_regs_t;

    even_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;

        // second butterfly layer
        r_d.mid.vld = sum_i.vld;
        if (sum_i.vld) begin
            r_d.mid.e0 = ev_t'(sum_i.s0) + ev_t'(sum_i.s3);
            r_d.mid.e1 = ev_t'(sum_i.s1) + ev_t'(sum_i.s2);
            r_d.mid.e2 = ev_t'(sum_i.s1) - ev_t'(sum_i.s2);
            r_d.mid.e3 = ev_t'(sum_i.s0) - ev_t'(sum_i.s3);
        end

        // cos(pi/4) scaling and the C6/S6 rotation
        r_d.rot.vld = r_q.mid.vld;
        if (r_q.mid.vld) begin
            r_d.rot.y0 = rot_pair(acc_t'(r_q.mid.e0) + acc_t'(r_q.mid.e1), K_C4H,
                                  '0, '0);
            r_d.rot.y4 = rot_pair(acc_t'(r_q.mid.e0) - acc_t'(r_q.mid.e1), K_C4H,
                                  '0, '0);
            r_d.rot.y2 = rot_pair(acc_t'(r_q.mid.e3), K_S6,
                                  acc_t'(r_q.mid.e2), K_C6);
            r_d.rot.y6 = rot_pair(acc_t'(r_q.mid.e3), K_C6,
                                  -acc_t'(r_q.mid.e2), K_S6);
        end

        // alignment stage: matches the deeper odd half
        r_d.aln.vld = r_q.rot.vld;
        if (r_q.rot.vld) begin
            r_d.aln.y0 = r_q.rot.y0;
            r_d.aln.y2 = r_q.rot.y2;
            r_d.aln.y4 = r_q.rot.y4;
            r_d.aln.y6 = r_q.rot.y6;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_o = r_q.aln;

    // antisymmetric input leaves nothing for the even half to produce
    assert_even_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mid.vld && r_q.mid.e0 == '0 && r_q.mid.e1 == '0 &&
         r_q.mid.e2 == '0 && r_q.mid.e3 == '0)
        |=> (r_q.rot.y0 == '0 && r_q.rot.y2 == '0 &&
             r_q.rot.y4 == '0 && r_q.rot.y6 == '0));

endmodule

// File: rtl/dct8_odd.sv
module dct8_odd
    import dct8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pair_dif_t dif_i,
    output odd_out_t  od_o
);

    typedef struct packed {
        odd_rot_t rot;
        odd_mid_t mid;
        odd_out_t fin;
    } odd_regs_t;

    odd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;

        // middle pair rotated by full-scale cos(pi/4)
        r_d.rot.vld = dif_i.vld;
        if (dif_i.vld) begin
            r_d.rot.rp = scale_c4(acc_t'(dif_i.d1) + acc_t'(dif_i.d2));
            r_d.rot.rm = scale_c4(acc_t'(dif_i.d1) - acc_t'(dif_i.d2));
            r_d.rot.o0 = dif_i.d0;
            r_d.rot.o3 = dif_i.d3;
        end

        // butterfly against the outer differences
        r_d.mid.vld = r_q.rot.vld;
        if (r_q.rot.vld) begin
            r_d.mid.ta = odd_t'(r_q.rot.o0) + r_q.rot.rp;
            r_d.mid.tb = odd_t'(r_q.rot.o0) - r_q.rot.rp;
            r_d.mid.tc = odd_t'(r_q.rot.o3) - r_q.rot.rm;
            r_d.mid.td = odd_t'(r_q.rot.o3) + r_q.rot.rm;
        end

        // final C7/S7 and C3/S3 rotations
        r_d.fin.vld = r_q.mid.vld;
        if (r_q.mid.vld) begin
            r_d.fin.y1 = rot_pair(acc_t'(r_q.mid.ta), K_S7,
                                  acc_t'(r_q.mid.td), K_C7);
            r_d.fin.y7 = rot_pair(acc_t'(r_q.mid.ta), K_C7,
                                  -acc_t'(r_q.mid.td), K_S7);
            r_d.fin.y3 = rot_pair(acc_t'(r_q.mid.tb), K_C3,
                                  -acc_t'(r_q.mid.tc), K_S3);
            r_d.fin.y5 = rot_pair(acc_t'(r_q.mid.tb), K_S3,
                                  acc_t'(r_q.mid.tc), K_C3);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign od_o = r_q.fin;

    // symmetric input zeroes every odd intermediate, so every odd result
    assert_odd_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mid.vld && r_q.mid.ta == '0 && r_q.mid.tb == '0 &&
         r_q.mid.tc == '0 && r_q.mid.td == '0)
        |=> (r_q.fin.y1 == '0 && r_q.fin.y3 == '0 &&
             r_q.fin.y5 == '0 && r_q.fin.y7 == '0));

endmodule

// File: rtl/dct8_fdct.sv
module dct8_fdct
    import dct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_samples,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_coef
);

    localparam int PIPE_LAT = 4;
    localparam int WARM_W   = $clog2(PIPE_LAT + 1);

    typedef struct packed {
        logic              rdy;
        logic [WARM_W-1:0] warm;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    logic      take;
    pair_sum_t st_sum;
    pair_dif_t st_dif;
    even_out_t ev;
    odd_out_t  od;
    smp_t      coef [NPT];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdy = 1'b1;
        if (ctl_q.warm != WARM_W'(PIPE_LAT)) begin
            ctl_d.warm = ctl_q.warm + WARM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = ctl_q.rdy;
    assign take     = in_valid && ctl_q.rdy;

    dct8_bfly u_bfly (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .smp_i  (in_samples),
        .sum_o  (st_sum),
        .dif_o  (st_dif)
    );

    dct8_even u_even (
        .clk   (clk),
        .rst_n (rst_n),
        .sum_i (st_sum),
        .ev_o  (ev)
    );

    dct8_odd u_odd (
        .clk   (clk),
        .rst_n (rst_n),
        .dif_i (st_dif),
        .od_o  (od)
    );

    // production order 0,4,2,6,1,5,3,7 sorted into index order
    always_comb begin
        coef[0] = ev.y0;
        coef[1] = od.y1;
        coef[2] = ev.y2;
        coef[3] = od.y3;
        coef[4] = ev.y4;
        coef[5] = od.y5;
        coef[6] = ev.y6;
        coef[7] = od.y7;
    end

    for (genvar k = 0; k < NPT; k++) begin : g_pack
        assign out_coef[k*DATA_W +: DATA_W] = coef[k];
    end

    assign out_valid = od.vld;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.warm == WARM_W'(PIPE_LAT)) |-> (out_valid == $past(take, 4)));

    assert_paths_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev.vld == od.vld);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_coef));

endmodule

// File: tb/dct8_fdct_tb.sv
module dct8_fdct_tb;

    localparam int  NV = 10;
    localparam real PI = 3.14159265358979323846;

    // sample n sits at bits 16n+15:16n, so each literal lists x7 first
    localparam logic [127:0] STIM [NV] = '{
        128'h0064_0064_0064_0064_0064_0064_0064_0064,  // flat, symmetric
        128'h1B58_1770_1388_0FA0_0BB8_07D0_03E8_0000,  // ramp
        128'hB1E0_4E20_B1E0_4E20_B1E0_4E20_B1E0_4E20,  // alternating, antisymmetric
        128'hFF85_1A85_F6D7_1ED2_F280_2334_E9D2_04D2,  // mixed
        128'h0000_0000_0000_0000_7530_0000_0000_0000,  // impulse on x3
        128'hEC78_0BB8_FC18_E4A8_1B58_03E8_F448_1388,  // antisymmetric
        128'hD120_0FA0_61A8_FED4_FED4_61A8_0FA0_D120,  // symmetric
        128'h7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF,  // full scale positive
        128'h8000_8000_8000_8000_8000_8000_8000_8000,  // full scale negative
        128'h8001_7FFF_8001_7FFF_8001_7FFF_8001_7FFF   // full alternating
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_samples;
    logic         out_valid;
    logic [127:0] out_coef;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    dct8_fdct u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .out_coef   (out_coef)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic real ref_coef(input logic [127:0] v, input int k);
        real acc = 0.0;
        for (int n = 0; n < 8; n++) begin
            acc += $itor($signed(v[16*n +: 16])) * $cos($itor((2*n + 1) * k) * PI / 16.0);
        end
        acc = acc / 4.0;
        if (k == 0) acc = acc / $sqrt(2.0);
        return acc;
    endfunction

    function automatic int coef_at(input logic [127:0] v, input int k);
        return int'($signed(v[16*k +: 16]));
    endfunction

    task automatic check_coefs(input logic [127:0] v, input string ctx);
        bit sym  = 1'b1;
        bit anti = 1'b1;
        for (int n = 0; n < 4; n++) begin
            if (coef_at(v, n) != coef_at(v, 7 - n))  sym  = 1'b0;
            if (coef_at(v, n) != -coef_at(v, 7 - n)) anti = 1'b0;
        end
        for (int k = 0; k < 8; k++) begin
            real   raw = ref_coef(v, k);
            real   exp_r;
            real   diff;
            int    act = coef_at(out_coef, k);
            string tag;
            exp_r = raw;
            if (exp_r > 32767.0)  exp_r = 32767.0;
            if (exp_r < -32768.0) exp_r = -32768.0;
            diff = $itor(act) - exp_r;
            if (diff < 0.0) diff = -diff;
            if (k == 0)          tag = "R3 R4";
            else if (k % 2 == 0) tag = "R3 R5";
            else                 tag = "R3 R6";
            chk(diff <= 2.0, $sformatf("%s %s coef%0d", tag, ctx, k), act, $rtoi(exp_r));
            if (raw > 32767.0 || raw < -32768.0) begin
                chk(act == $rtoi(exp_r), $sformatf("R9 %s coef%0d clamp", ctx, k),
                    act, $rtoi(exp_r));
            end
            if (sym && (k % 2 == 1)) begin
                chk(act == 0, $sformatf("R7 %s coef%0d", ctx, k), act, 0);
            end
            if (anti && (k % 2 == 0)) begin
                chk(act == 0, $sformatf("R8 %s coef%0d", ctx, k), act, 0);
            end
        end
    endtask

    // called at a falling edge; returns one falling edge later with in_valid low
    task automatic send(input logic [127:0] v);
        in_samples = v;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_samples = '0;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk(out_valid == 1'b0, "R10 reset out_valid", longint'(out_valid), 0);
        chk(out_coef == '0, "R10 reset out_coef zero", longint'(out_coef != '0), 0);
        chk(in_ready == 1'b0, "R10 reset in_ready", longint'(in_ready), 0);

        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 in_ready after reset", longint'(in_ready), 1);

        // table walk, one vector at a time
        for (int i = 0; i < NV; i++) begin
            send(STIM[i]);
            chk(out_valid == 1'b0, $sformatf("R1 vec%0d early cycle1", i), longint'(out_valid), 0);
            @(negedge clk);
            @(negedge clk);
            chk(out_valid == 1'b0, $sformatf("R1 vec%0d early cycle3", i), longint'(out_valid), 0);
            @(negedge clk);
            chk(out_valid == 1'b1, $sformatf("R1 vec%0d on time", i), longint'(out_valid), 1);
            check_coefs(STIM[i], $sformatf("vec%0d", i));
            @(negedge clk);
            chk(out_valid == 1'b0, $sformatf("R1 vec%0d single pulse", i), longint'(out_valid), 0);
        end

        // R10: outputs hold while idle
        held = out_coef;
        repeat (3) @(negedge clk);
        chk(out_coef == held, "R10 hold while idle", longint'(out_coef != held), 0);
        chk(out_valid == 1'b0, "R10 idle out_valid", longint'(out_valid), 0);

        // R2: back-to-back vectors
        in_valid   = 1'b1;
        in_samples = STIM[3];
        @(negedge clk);
        in_samples = STIM[1];
        @(negedge clk);
        in_samples = STIM[6];
        @(negedge clk);
        in_valid   = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 burst result0 valid", longint'(out_valid), 1);
        check_coefs(STIM[3], "R2 burst0");
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 burst result1 valid", longint'(out_valid), 1);
        check_coefs(STIM[1], "R2 burst1");
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 burst result2 valid", longint'(out_valid), 1);
        check_coefs(STIM[6], "R2 burst2");
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 burst end", longint'(out_valid), 0);

        // R10: reset while a vector is in flight
        send(STIM[7]);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 flush out_valid", longint'(out_valid), 0);
        chk(out_coef == '0, "R10 flush out_coef zero", longint'(out_coef != '0), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, $sformatf("R10 flushed vector absent c%0d", c),
                longint'(out_valid), 0);
        end

        // R1: pipeline usable again after the flush
        send(STIM[4]);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1, "R1 after flush", longint'(out_valid), 1);
        check_coefs(STIM[4], "after flush");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule